// File: doc/BRIEF.md
# Tri-Level Half-Bridge Dead-Time Controller

This block turns a three-valued switching command into the two gate enables of a half bridge. A high command selects the upper switch, a low command selects the lower switch, and a middle command parks both switches off. Each turn-on is held back by a programmable dead time, counted in clock cycles, so that one switch is always fully off before the other turns on. Turn-off is never delayed.

The command reaches the block already sliced into a 2-bit code. An enable input overrides everything and forces both gates off. The dead-time setting comes from a configuration input, and the block clamps it into a supported window. The dead-time count starts from the first clock edge that samples a valid high or low level. Any time the command spends at the middle level before that edge therefore adds to the gap between the two conduction intervals.

Top module: `tlpwm_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted, both gate outputs are 0 after the next clock edge.
- R2: A high command (code 2'b10) with enable set drives `hs_o`=1 and `ls_o`=0, starting at the D-th rising edge after the first edge that samples it. D is the clamped dead-time setting.
- R3: A low command (code 2'b00) with enable set drives `ls_o`=1 and `hs_o`=0, with the same D-edge delay as R2.
- R4: A middle command (code 2'b01) clears both outputs at the next edge and keeps them cleared for as long as it is applied.
- R5: Code 2'b11 behaves exactly like the middle code: both outputs stay 0.
- R6: When `en_i` is 0, both outputs are 0 after the next edge, whatever the command.
- R7: Turn-off is immediate. An output that is on goes to 0 at the first edge that samples a command (or enable) no longer selecting it, with no dead time.
- R8: The dead time counts from the edge where the command arrives at high or low. Any cycles spent at the middle level before that edge add to the off interval.
- R9: If the command changes while a dead time is running, the count restarts in full for the new high or low target. If the new command is middle, the count is abandoned.
- R10: The dead-time setting `dt_cfg_i` is sampled at the edge that starts a count and clamped into 5..44 cycles. Values below 5 act as 5 and values above 44 act as 44.
- R11: After enable returns to 1, a full dead time passes before either output turns on.
- R12: `hs_o` and `ls_o` are never both 1 in the same cycle, and an output rises only after a cycle in which the other output was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable; 0 forces both gates off |
| cmd_i | input | 2 | Command: 00 low, 01 middle, 10 high, 11 middle |
| dt_cfg_i | input | DT_W (6) | Dead time in clock cycles, clamped to 5..44 |
| hs_o | output | 1 | Upper switch gate enable (registered) |
| ls_o | output | 1 | Lower switch gate enable (registered) |

## Verification
The command is driven through several patterns:
- Direct high-to-low and low-to-high swaps show that turn-off is immediate while turn-on waits exactly D edges.
- A middle dwell placed before a new level shows that the count begins only on arrival at the new level.
- Toggling the command mid-count shows the count restarting for a new target and being abandoned when the command goes to middle.
- Settings below, inside and above the window separate clamping from a plain pass-through.
- Dropping and restoring enable during conduction confirms the override and the full dead time that follows it.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;
  typedef enum logic [1:0] {
    SIDE_OFF = 2'd0,
    SIDE_LO  = 2'd1,
    SIDE_HI  = 2'd2
  } side_e;

  localparam logic [1:0] CMD_LOW  = 2'b00;
  localparam logic [1:0] CMD_HIGH = 2'b10;
endpackage

// File: rtl/tlpwm_decode.sv
module tlpwm_decode
  import tlpwm_pkg::*;
(
  input  logic       en_i,
  input  logic [1:0] cmd_i,
  output side_e      want_o
);
  always_comb begin
    if (!en_i)                  want_o = SIDE_OFF;
    else if (cmd_i == CMD_HIGH) want_o = SIDE_HI;
    else if (cmd_i == CMD_LOW)  want_o = SIDE_LO;
    else                        want_o = SIDE_OFF;  // 01 and 11 both park
  end
endmodule

// File: rtl/tlpwm_dt_timer.sv
module tlpwm_dt_timer #(
  parameter int DT_W   = 6,
  parameter int DT_MIN = 5,
  parameter int DT_MAX = 44
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_i,
  input  logic            clear_i,
  input  logic [DT_W-1:0] dt_cfg_i,
  output logic            ready_o
);
  localparam logic [DT_W-1:0] LO_LIM = DT_W'(DT_MIN);
  localparam logic [DT_W-1:0] HI_LIM = DT_W'(DT_MAX);

  logic [DT_W-1:0] dt_eff;
  logic [DT_W-1:0] cnt_q;

  always_comb begin
    if (dt_cfg_i < LO_LIM)      dt_eff = LO_LIM;
    else if (dt_cfg_i > HI_LIM) dt_eff = HI_LIM;
    else                        dt_eff = dt_cfg_i;
  end

  // Loaded with D-1 so the consumer's registered output rises on edge D.
  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i)  cnt_q <= '0;
    else if (start_i)      cnt_q <= dt_eff - DT_W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - DT_W'(1);
  end

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/tlpwm_out_fsm.sv
module tlpwm_out_fsm
  import tlpwm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  side_e want_i,
  input  logic  ready_i,
  output logic  start_o,
  output logic  clear_o,
  output logic  hs_o,
  output logic  ls_o
);
  side_e tgt_q;
  logic  change;

  assign change  = (want_i != tgt_q);
  assign start_o = change && (want_i != SIDE_OFF);
  assign clear_o = change && (want_i == SIDE_OFF);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tgt_q <= SIDE_OFF;
      hs_o  <= 1'b0;
      ls_o  <= 1'b0;
    end else if (change) begin
      tgt_q <= want_i;
      hs_o  <= 1'b0;
      ls_o  <= 1'b0;
    end else begin
      hs_o <= (want_i == SIDE_HI) && ready_i;
      ls_o <= (want_i == SIDE_LO) && ready_i;
    end
  end
endmodule

// File: rtl/tlpwm_ctrl.sv
module tlpwm_ctrl
  import tlpwm_pkg::*;
#(
  parameter int DT_W   = 6,
  parameter int DT_MIN = 5,
  parameter int DT_MAX = 44
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            en_i,
  input  logic [1:0]      cmd_i,
  input  logic [DT_W-1:0] dt_cfg_i,
  output logic            hs_o,
  output logic            ls_o
);
  side_e want;
  logic  start, clear, ready;

  tlpwm_decode u_dec (
    .en_i  (en_i),
    .cmd_i (cmd_i),
    .want_o(want)
  );

  tlpwm_dt_timer #(.DT_W(DT_W), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u_tmr (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start),
    .clear_i (clear),
    .dt_cfg_i(dt_cfg_i),
    .ready_o (ready)
  );

  tlpwm_out_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .want_i (want),
    .ready_i(ready),
    .start_o(start),
    .clear_o(clear),
    .hs_o   (hs_o),
    .ls_o   (ls_o)
  );
endmodule

// File: rtl/tlpwm_chk.sv
module tlpwm_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       en_i,
  input logic [1:0] cmd_i,
  input logic       hs_o,
  input logic       ls_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk_i)
    rst_i |=> (!hs_o && !ls_o));

  // R12
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(hs_o && ls_o));

  // R12
  hs_rise_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hs_o) |-> !$past(ls_o));

  // R12
  ls_rise_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ls_o) |-> !$past(hs_o));

  // R6
  enable_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!hs_o && !ls_o));

  // R4
  mid_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == 2'b01) |=> (!hs_o && !ls_o));

  // R5
  code3_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == 2'b11) |=> (!hs_o && !ls_o));

  // R7
  hs_fast_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hs_o && cmd_i != 2'b10) |=> !hs_o);

  // R7
  ls_fast_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ls_o && cmd_i != 2'b00) |=> !ls_o);
endmodule

bind tlpwm_ctrl tlpwm_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
  .cmd_i(cmd_i), .hs_o(hs_o), .ls_o(ls_o)
);

// File: tb/tlpwm_ctrl_bench.sv
module tlpwm_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] cmd = 2'b01;
  logic [5:0] dt  = 6'd10;
  logic       hs, ls;

  typedef struct {
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad   = 0;

  // reference state: 0 off, 1 low side, 2 high side
  int m_want = 0;
  int m_run  = 0;
  int m_d    = 0;

  always #5 clk = ~clk;

  tlpwm_ctrl u_tlpwm_ctrl (
    .clk_i(clk), .rst_i(rst), .en_i(en), .cmd_i(cmd),
    .dt_cfg_i(dt), .hs_o(hs), .ls_o(ls)
  );

  function automatic int lim(input int v);
    return (v < 5) ? 5 : ((v > 44) ? 44 : v);
  endfunction

  task automatic step(input logic r, input logic e, input logic [1:0] c,
                      input logic [5:0] d, input string tag);
    int   w;
    exp_t it;
    @(negedge clk);
    rst = r; en = e; cmd = c; dt = d;
    w = !e ? 0 : (c == 2'b10 ? 2 : (c == 2'b00 ? 1 : 0));
    if (r) begin
      m_want = 0; m_run = 0;
    end else if (w != m_want) begin
      m_want = w; m_run = 1; m_d = lim(int'(d));
    end else begin
      m_run++;
    end
    it.hs  = !r && (m_want == 2) && (m_run > m_d);
    it.ls  = !r && (m_want == 1) && (m_run > m_d);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic hold(input int n, input logic e, input logic [1:0] c,
                      input logic [5:0] d, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, e, c, d, tag);
  endtask

  // monitor: compare each edge's result against the queued expectation
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (hs !== it.hs || ls !== it.ls) begin
          bad++;
          $display("FAIL %s: hs/ls actual=%b%b expected=%b%b at %0t",
                   it.tag, hs, ls, it.hs, it.ls, $time);
        end
        total++;
        if (hs && ls) begin
          bad++;
          $display("FAIL R12: hs/ls actual=11 expected=not both at %0t", $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hold(0, 1'b0, 2'b01, 6'd10, "R1");
    step(1'b1, 1'b1, 2'b10, 6'd10, "R1");
    step(1'b1, 1'b1, 2'b10, 6'd10, "R1");
    hold(14, 1'b1, 2'b10, 6'd10, "R2");      // high, D=10
    hold(12, 1'b1, 2'b00, 6'd10, "R3");      // direct swap to low
    hold(3,  1'b1, 2'b10, 6'd10, "R7");      // immediate off of low
    hold(10, 1'b1, 2'b10, 6'd10, "R2");
    hold(6,  1'b1, 2'b01, 6'd10, "R4");      // middle parks both
    hold(6,  1'b1, 2'b11, 6'd10, "R5");      // code 3 also parks
    hold(9,  1'b1, 2'b00, 6'd7,  "R8");      // low after middle dwell
    hold(5,  1'b1, 2'b01, 6'd7,  "R8");
    hold(10, 1'b1, 2'b10, 6'd7,  "R8");
    hold(3,  1'b1, 2'b00, 6'd8,  "R9");      // partial count
    hold(4,  1'b1, 2'b10, 6'd8,  "R9");      // restart for high
    hold(2,  1'b1, 2'b01, 6'd8,  "R9");      // abandon
    hold(11, 1'b1, 2'b10, 6'd8,  "R9");
    hold(8,  1'b1, 2'b00, 6'd2,  "R10");     // clamps up to 5
    hold(4,  1'b1, 2'b01, 6'd63, "R10");
    hold(48, 1'b1, 2'b10, 6'd63, "R10");     // clamps down to 44
    hold(5,  1'b0, 2'b10, 6'd6,  "R6");      // enable override
    hold(10, 1'b1, 2'b10, 6'd6,  "R11");     // full dead time after enable
    hold(3,  1'b0, 2'b00, 6'd6,  "R6");
    hold(9,  1'b1, 2'b00, 6'd6,  "R11");
    step(1'b1, 1'b1, 2'b00, 6'd6, "R1");
    hold(3,  1'b1, 2'b00, 6'd6,  "R1");
    repeat (3) @(posedge clk);
    #3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule